// File: doc/BRIEF.md
# Two-Wide In-Order Issue Scoreboard

This block sits at the issue point of a two-wide, strictly in-order scalar pipeline. Each cycle the decoder offers an ordered pair of instructions: an older slot 0 and a younger slot 1. Each carries a class code, a destination register and two source registers. The block decides how many of the pair leave this cycle, zero, one or two, and never lets the younger one go ahead of the older one. It bases that choice on two checks. The first is a countdown per architectural register that tracks when a pending result becomes readable. The second is a small set of occupancy counters for the execution units that stay busy over several cycles.

The integer lanes are not symmetric. Lane 0 is the only lane that takes control transfers and the long divide. While a divide is running, lane 0 refuses new work, but lane 1 keeps taking simple arithmetic. Loads and stores share two memory units. Floating-point arithmetic has a single pipelined unit of its own.

The decision for a pair is registered. The issue count, the unit chosen for each slot and the stall flag appear on the outputs one clock after the pair is presented, and the scoreboard reflects the issue from that same edge. The front end offers a pair for one cycle and offers it again if it was not fully taken.

Top module: `dual_issue_sb`

## Requirements
- R1: After a synchronous active-high reset, `issue_cnt`, `s0_unit`, `s1_unit` and `stall` are 0, and no register is pending, so the first independent pair issues in full.
- R2: Class codes are 0 simple integer, 1 control transfer, 2 divide, 3 load, 4 store and 5 floating-point; codes 6 and 7 act as simple integer. Unit codes are 0 none, 1 integer lane 0, 2 integer lane 1, 3 memory unit 0, 4 memory unit 1 and 5 floating-point unit. Two independent simple integer instructions issue together, with slot 0 on lane 0 and slot 1 on lane 1. The result for a pair presented at one clock edge appears on the outputs right after that edge.
- R3: A simple integer result can be read by an instruction presented on the very next cycle.
- R4: Control transfers and divides issue only on lane 0. Two control transfers in one pair issue one at a time. When slot 1 needs lane 0, a simple integer instruction in slot 0 takes lane 1, so that both issue.
- R5: A divide occupies lane 0 for its issue cycle and the 19 cycles after it, 20 cycles in all. During that window a control transfer stalls, two simple integer instructions issue one per cycle on lane 1, and the divide result can be read 20 cycles after issue.
- R6: A load goes to memory unit 0 if that unit is free and to unit 1 otherwise, so two loads can issue together. A reader of the loaded register can issue 5 cycles after the load and no sooner.
- R7: A store keeps its memory unit busy for 3 cycles, starting with its issue cycle. A store writes no register, so its destination field is ignored.
- R8: Floating-point instructions use one unit and issue one per cycle. They can pair with integer work, and their results can be read 4 cycles after issue.
- R9: An older instruction that reads a pending register stalls, and the younger slot does not issue that cycle even if it is independent.
- R10: When slot 1 reads or writes the non-zero destination of slot 0, only slot 0 issues.
- R11: An instruction whose destination register is still pending stalls until that register is ready.
- R12: Register 0 is never pending. Writing it and reading it in the same pair, or right after a load to it, causes no stall.
- R13: While `flush` is high nothing issues and all outputs are 0. On the next cycle all pending registers and the divide occupancy are clear.
- R14: `stall` is 1 exactly when fewer instructions issued than were valid. Slot 1 counts as valid only when slot 0 is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears pending state and blocks issue this cycle |
| s0_vld | input | 1 | Older slot valid |
| s0_cls | input | 3 | Older slot class code |
| s0_rd | input | RW | Older slot destination register |
| s0_rs1 | input | RW | Older slot first source |
| s0_rs2 | input | RW | Older slot second source |
| s1_vld | input | 1 | Younger slot valid |
| s1_cls | input | 3 | Younger slot class code |
| s1_rd | input | RW | Younger slot destination register |
| s1_rs1 | input | RW | Younger slot first source |
| s1_rs2 | input | RW | Younger slot second source |
| issue_cnt | output | 2 | Number issued from the pair (registered) |
| s0_unit | output | 3 | Unit given to slot 0, 0 if not issued (registered) |
| s1_unit | output | 3 | Unit given to slot 1, 0 if not issued (registered) |
| stall | output | 1 | Some valid instruction was held back (registered) |

## Verification
A countdown that is off by one shows up at the ports within a single cycle. The bench presents a reader on every cycle after the producer, so a wrong count makes the issue count switch from 0 to 1 one cycle early or late on the boundary the bench samples. Divide and store occupancy errors show up the same way, on the cycle where a control transfer or a load first stops stalling. A missing flush, or a wrong lane preference, changes the unit codes or the issue count of the pair presented right after.

// File: rtl/iss_pkg.sv
package iss_pkg;
  typedef enum logic [2:0] {
    C_ALU = 3'd0, C_BR = 3'd1, C_DIV = 3'd2, C_LD = 3'd3, C_ST = 3'd4, C_FP = 3'd5
  } cls_t;

  typedef enum logic [2:0] {
    U_NONE = 3'd0, U_ALU0 = 3'd1, U_ALU1 = 3'd2, U_LSU0 = 3'd3, U_LSU1 = 3'd4, U_FPU = 3'd5
  } unit_t;

  // unused codes fall back to simple integer
  function automatic cls_t kind(input logic [2:0] c);
    if (c > 3'd5) return C_ALU;
    return cls_t'(c);
  endfunction

  function automatic logic has_dst(input cls_t k);
    return k != C_ST;
  endfunction
endpackage

// File: rtl/sb_regs.sv
module sb_regs #(
  parameter int NREG = 32,
  parameter int RW   = 5,
  parameter int CW   = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic [1:0]            wr_en,
  input  logic [1:0][RW-1:0]    wr_idx,
  input  logic [1:0][CW-1:0]    wr_val,
  output logic [NREG-1:0]       busy
);
  assign busy[0] = 1'b0;

  for (genvar r = 1; r < NREG; r++) begin : g_reg
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst || flush)                               cnt <= '0;
      else if (wr_en[0] && wr_idx[0] == RW'(r))       cnt <= wr_val[0];
      else if (wr_en[1] && wr_idx[1] == RW'(r))       cnt <= wr_val[1];
      else if (cnt != '0)                             cnt <= cnt - 1'b1;
    end
    assign busy[r] = (cnt != '0);
  end

  // R13
  sb_flush_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (busy == '0));

  // R11
  sb_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en[0] && wr_val[0] != '0 && !flush) |=> busy[$past(wr_idx[0])]);
endmodule

// File: rtl/unit_track.sv
module unit_track #(
  parameter int DIV_LAT = 20,
  parameter int ST_OCC  = 3,
  localparam int DW = $clog2(DIV_LAT + 1),
  localparam int SW = $clog2(ST_OCC + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       div_go,
  input  logic [1:0] st_go,
  output logic       div_busy,
  output logic [1:0] lsu_busy
);
  logic [DW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst || flush)      div_cnt <= '0;
    else if (div_go)       div_cnt <= DW'(DIV_LAT - 1);
    else if (div_cnt != 0) div_cnt <= div_cnt - 1'b1;
  end
  assign div_busy = (div_cnt != '0);

  for (genvar u = 0; u < 2; u++) begin : g_lsu
    logic [SW-1:0] occ;
    always_ff @(posedge clk) begin
      if (rst || flush)   occ <= '0;
      else if (st_go[u])  occ <= SW'(ST_OCC - 1);
      else if (occ != 0)  occ <= occ - 1'b1;
    end
    assign lsu_busy[u] = (occ != '0);
  end

  // R5
  ut_div_chk: assert property (@(posedge clk) disable iff (rst)
    (div_go && !flush) |=> div_busy);

  // R7
  ut_store_chk: assert property (@(posedge clk) disable iff (rst)
    (st_go[0] && !flush) |=> lsu_busy[0]);
endmodule

// File: rtl/pair_pick.sv
module pair_pick
  import iss_pkg::*;
#(
  parameter int NREG = 32,
  parameter int RW   = 5
) (
  input  logic            flush,
  input  logic            v0,
  input  cls_t            k0,
  input  logic [RW-1:0]   d0, a0, b0,
  input  logic            v1,
  input  cls_t            k1,
  input  logic [RW-1:0]   d1, a1, b1,
  input  logic [NREG-1:0] busy,
  input  logic            div_busy,
  input  logic [1:0]      lsu_busy,
  output logic            iss0,
  output logic            iss1,
  output unit_t           u0,
  output unit_t           u1
);
  unit_t c0, c1;
  logic  raw0, raw1, intra, lane0_young;

  always_comb begin
    raw0 = busy[a0] | busy[b0] | (has_dst(k0) & busy[d0]);
    raw1 = busy[a1] | busy[b1] | (has_dst(k1) & busy[d1]);
    intra = has_dst(k0) && d0 != '0 &&
            (a1 == d0 || b1 == d0 || (has_dst(k1) && d1 == d0));
    lane0_young = v1 && (k1 == C_BR || k1 == C_DIV);

    c0 = U_NONE;
    unique case (k0)
      C_ALU:       c0 = (lane0_young || div_busy) ? U_ALU1 : U_ALU0;
      C_BR, C_DIV: c0 = div_busy ? U_NONE : U_ALU0;
      C_LD, C_ST:  c0 = !lsu_busy[0] ? U_LSU0 : (!lsu_busy[1] ? U_LSU1 : U_NONE);
      default:     c0 = U_FPU;
    endcase

    c1 = U_NONE;
    unique case (k1)
      C_ALU:
        if (c0 != U_ALU1)                      c1 = U_ALU1;
        else if (!div_busy && c0 != U_ALU0)    c1 = U_ALU0;
      C_BR, C_DIV:
        if (!div_busy && c0 != U_ALU0)         c1 = U_ALU0;
      C_LD, C_ST:
        if (!lsu_busy[0] && c0 != U_LSU0)      c1 = U_LSU0;
        else if (!lsu_busy[1] && c0 != U_LSU1) c1 = U_LSU1;
      default:
        if (c0 != U_FPU)                       c1 = U_FPU;
    endcase

    iss0 = v0 && !flush && !raw0 && c0 != U_NONE;
    iss1 = iss0 && v1 && !raw1 && !intra && c1 != U_NONE;
    u0   = iss0 ? c0 : U_NONE;
    u1   = iss1 ? c1 : U_NONE;
  end
endmodule

// File: rtl/dual_issue_sb.sv
module dual_issue_sb
  import iss_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int DIV_LAT = 20,
  parameter int LD_LAT  = 5,
  parameter int ST_OCC  = 3,
  parameter int FP_LAT  = 4,
  localparam int RW = $clog2(NREG),
  localparam int CW = $clog2(DIV_LAT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          s0_vld,
  input  logic [2:0]    s0_cls,
  input  logic [RW-1:0] s0_rd,
  input  logic [RW-1:0] s0_rs1,
  input  logic [RW-1:0] s0_rs2,
  input  logic          s1_vld,
  input  logic [2:0]    s1_cls,
  input  logic [RW-1:0] s1_rd,
  input  logic [RW-1:0] s1_rs1,
  input  logic [RW-1:0] s1_rs2,
  output logic [1:0]    issue_cnt,
  output logic [2:0]    s0_unit,
  output logic [2:0]    s1_unit,
  output logic          stall
);
  cls_t             k0, k1;
  logic [NREG-1:0]  busy;
  logic             div_busy, iss0, iss1, div_go;
  logic [1:0]       lsu_busy, st_go, wr_en;
  logic [1:0][RW-1:0] wr_idx;
  logic [1:0][CW-1:0] wr_val;
  unit_t            u0, u1;

  assign k0 = kind(s0_cls);
  assign k1 = kind(s1_cls);

  function automatic logic [CW-1:0] wait_of(input cls_t k);
    unique case (k)
      C_DIV:   return CW'(DIV_LAT - 1);
      C_LD:    return CW'(LD_LAT - 1);
      C_FP:    return CW'(FP_LAT - 1);
      default: return '0;
    endcase
  endfunction

  pair_pick #(.NREG(NREG), .RW(RW)) u_pick (
    .flush(flush), .v0(s0_vld), .k0(k0), .d0(s0_rd), .a0(s0_rs1), .b0(s0_rs2),
    .v1(s1_vld), .k1(k1), .d1(s1_rd), .a1(s1_rs1), .b1(s1_rs2),
    .busy(busy), .div_busy(div_busy), .lsu_busy(lsu_busy),
    .iss0(iss0), .iss1(iss1), .u0(u0), .u1(u1)
  );

  always_comb begin
    wr_en[0]  = iss0 && has_dst(k0) && s0_rd != '0;
    wr_en[1]  = iss1 && has_dst(k1) && s1_rd != '0;
    wr_idx[0] = s0_rd;
    wr_idx[1] = s1_rd;
    wr_val[0] = wait_of(k0);
    wr_val[1] = wait_of(k1);
    div_go    = (iss0 && k0 == C_DIV) || (iss1 && k1 == C_DIV);
    st_go[0]  = (iss0 && k0 == C_ST && u0 == U_LSU0) || (iss1 && k1 == C_ST && u1 == U_LSU0);
    st_go[1]  = (iss0 && k0 == C_ST && u0 == U_LSU1) || (iss1 && k1 == C_ST && u1 == U_LSU1);
  end

  sb_regs #(.NREG(NREG), .RW(RW), .CW(CW)) u_sb (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val), .busy(busy)
  );

  unit_track #(.DIV_LAT(DIV_LAT), .ST_OCC(ST_OCC)) u_units (
    .clk(clk), .rst(rst), .flush(flush),
    .div_go(div_go), .st_go(st_go), .div_busy(div_busy), .lsu_busy(lsu_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_cnt <= '0;
      s0_unit   <= '0;
      s1_unit   <= '0;
      stall     <= 1'b0;
    end else begin
      issue_cnt <= {1'b0, iss0} + {1'b0, iss1};
      s0_unit   <= u0;
      s1_unit   <= u1;
      stall     <= !flush && ((s0_vld && !iss0) || (s0_vld && s1_vld && !iss1));
    end
  end

  // R9
  order_chk: assert property (@(posedge clk) disable iff (rst)
    iss1 |-> iss0);

  // R2
  distinct_unit_chk: assert property (@(posedge clk) disable iff (rst)
    (iss0 && iss1) |-> (u0 != u1));

  // R5
  div_lane_chk: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> (u0 != U_ALU0 && u1 != U_ALU0));

  // R13
  flush_out_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (issue_cnt == 2'd0 && !stall));
endmodule

// File: tb/tb_dual_issue_sb.sv
`timescale 1ns/100ps
module tb_dual_issue_sb;
  localparam int A = 0, B = 1, D = 2, L = 3, S = 4, F = 5;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic s0_vld = 0, s1_vld = 0;
  logic [2:0] s0_cls = 0, s1_cls = 0;
  logic [4:0] s0_rd = 0, s0_rs1 = 0, s0_rs2 = 0, s1_rd = 0, s1_rs1 = 0, s1_rs2 = 0;
  logic [1:0] issue_cnt;
  logic [2:0] s0_unit, s1_unit;
  logic       stall;

  typedef struct { int cnt; int u0; int u1; int st; string tag; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  dual_issue_sb dut (
    .clk(clk), .rst(rst), .flush(flush),
    .s0_vld(s0_vld), .s0_cls(s0_cls), .s0_rd(s0_rd), .s0_rs1(s0_rs1), .s0_rs2(s0_rs2),
    .s1_vld(s1_vld), .s1_cls(s1_cls), .s1_rd(s1_rd), .s1_rs1(s1_rs1), .s1_rs2(s1_rs2),
    .issue_cnt(issue_cnt), .s0_unit(s0_unit), .s1_unit(s1_unit), .stall(stall)
  );

  task automatic compare(input exp_t e);
    total++;
    if (int'(issue_cnt) != e.cnt || int'(s0_unit) != e.u0 ||
        int'(s1_unit) != e.u1 || int'(stall) != e.st) begin
      bad++;
      $display("FAIL %s: got cnt=%0d u0=%0d u1=%0d stall=%0d, expected cnt=%0d u0=%0d u1=%0d stall=%0d",
               e.tag, issue_cnt, s0_unit, s1_unit, stall, e.cnt, e.u0, e.u1, e.st);
    end
  endtask

  // monitor: pops one expectation per presented pair
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic put(input int v0, c0, d0, a0, b0, v1, c1, d1, a1, b1, fl,
                     input int ecnt, eu0, eu1, est, input string tag);
    exp_t e;
    @(negedge clk);
    s0_vld = v0[0]; s0_cls = c0[2:0]; s0_rd = d0[4:0]; s0_rs1 = a0[4:0]; s0_rs2 = b0[4:0];
    s1_vld = v1[0]; s1_cls = c1[2:0]; s1_rd = d1[4:0]; s1_rs1 = a1[4:0]; s1_rs2 = b1[4:0];
    flush = fl[0];
    e.cnt = ecnt; e.u0 = eu0; e.u1 = eu1; e.st = est; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic one(input int c, d, a, b, ecnt, eu0, est, input string tag);
    put(1, c, d, a, b, 0, 0, 0, 0, 0, 0, ecnt, eu0, 0, est, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s0_vld = 0; s1_vld = 0; flush = 0;
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got no end, expected end of run");
    summary();
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    r.cnt = 0; r.u0 = 0; r.u1 = 0; r.st = 0; r.tag = "R1 reset";
    compare(r);

    put(1, A, 1, 0, 0, 1, A, 2, 0, 0, 0, 2, 1, 2, 0, "R1 R2 first pair");
    put(1, A, 3, 1, 0, 1, A, 4, 2, 0, 0, 2, 1, 2, 0, "R3 back-to-back");
    put(1, A, 5, 0, 0, 1, A, 6, 5, 0, 0, 1, 1, 0, 1, "R10 reads older dst");
    put(1, A, 7, 0, 0, 1, A, 7, 0, 0, 0, 1, 1, 0, 1, "R10 same dst");
    put(1, A, 0, 0, 0, 1, A, 8, 0, 0, 0, 2, 1, 2, 0, "R12 x0 in pair");
    one(L, 0, 0, 0, 1, 3, 0, "R12 load x0");
    one(A, 9, 0, 0, 1, 1, 0, "R12 read x0");
    put(1, B, 0, 0, 0, 1, B, 0, 0, 0, 0, 1, 1, 0, 1, "R4 two branches");
    put(1, A, 10, 0, 0, 1, B, 0, 0, 0, 0, 2, 2, 1, 0, "R4 alu yields lane0");
    put(1, B, 0, 0, 0, 1, A, 11, 0, 0, 0, 2, 1, 2, 0, "R4 branch first");
    put(0, 0, 0, 0, 0, 1, A, 12, 0, 0, 0, 0, 0, 0, 0, "R14 young alone");

    put(1, L, 12, 0, 0, 1, L, 13, 0, 0, 0, 2, 3, 4, 0, "R6 two loads");
    for (int k = 1; k <= 4; k++) one(A, 14, 12, 0, 0, 0, 1, "R6 load wait");
    one(A, 14, 12, 0, 1, 1, 0, "R6 load ready");

    one(L, 15, 0, 0, 1, 3, 0, "R9 load");
    put(1, A, 16, 15, 0, 1, A, 17, 0, 0, 0, 0, 0, 0, 1, "R9 young held");
    idle(6);

    one(L, 18, 0, 0, 1, 3, 0, "R11 load");
    one(A, 18, 0, 0, 0, 0, 1, "R11 waw");
    idle(6);

    put(1, S, 0, 1, 2, 1, S, 0, 3, 4, 0, 2, 3, 4, 0, "R7 two stores");
    one(L, 19, 0, 0, 0, 0, 1, "R7 lsu busy 1");
    one(L, 19, 0, 0, 0, 0, 1, "R7 lsu busy 2");
    one(L, 19, 0, 0, 1, 3, 0, "R7 lsu free");
    idle(6);
    one(S, 20, 0, 0, 1, 3, 0, "R7 store rd");
    one(A, 21, 20, 0, 1, 1, 0, "R7 store no dst");
    idle(4);

    put(1, F, 22, 0, 0, 1, F, 23, 0, 0, 0, 1, 5, 0, 1, "R8 one fpu");
    put(1, F, 24, 0, 0, 1, A, 25, 0, 0, 0, 2, 5, 2, 0, "R8 fp with alu");
    for (int k = 1; k <= 3; k++) one(A, 26, 24, 0, 0, 0, 1, "R8 fp wait");
    one(A, 26, 24, 0, 1, 1, 0, "R8 fp ready");
    idle(5);

    one(D, 27, 0, 0, 1, 1, 0, "R5 divide");
    put(1, A, 28, 0, 0, 1, A, 29, 0, 0, 0, 1, 2, 0, 1, "R5 lane1 only");
    one(B, 0, 0, 0, 0, 0, 1, "R5 branch blocked");
    idle(15);
    one(A, 30, 27, 0, 0, 0, 1, "R5 result pending");
    one(B, 0, 0, 0, 0, 0, 1, "R5 last busy cycle");
    put(1, B, 0, 0, 0, 1, A, 31, 27, 0, 0, 2, 1, 2, 0, "R5 lane0 free");

    put(1, A, 1, 0, 0, 1, D, 2, 0, 0, 0, 2, 2, 1, 0, "R4 alu plus divide");
    put(1, B, 0, 0, 0, 1, A, 3, 0, 0, 1, 0, 0, 0, 0, "R13 flush cycle");
    put(1, B, 0, 0, 0, 1, A, 3, 2, 0, 0, 2, 1, 2, 0, "R13 after flush");
    idle(3);
    summary();
  end
endmodule